// File: doc/BRIEF.md
# Bidirectional Reset Sequencer

This block controls reset for a processor subsystem. A software reset strobe, a watchdog timeout strobe or a low level on the external reset pin starts an internal reset sequence of fixed length. When software has armed bidirectional mode, a software or watchdog reset also pulls the open-drain reset pin low, so that external devices on the same reset net are reset as well. A one-hot source register records the cause of the last completed sequence. Start-up code reads it.

The pin level reaches the sequencer through a filter, which is modelled here as a delay line. The filter delay has a side effect. After a bidirectional reset releases the pin, the filtered level can still be low when it is sampled a fixed number of cycles later. The sequencer then starts a hardware reset, and that reset overwrites the recorded software or watchdog cause. The hardware reset is classed as short, or as long if the pin stays low long enough. A strap that selects internal flash lengthens the internal reset well past the pin release. With the strap set, the late sample sees a high level and no hardware reset follows.

Top module: `bidir_rst_seq`

## Requirements
- R1: After power-on reset, `int_rst`, `pin_pull` and `bden` are low and `src_flags` is 0.
- R2: A software or watchdog strobe received while idle holds `int_rst` high for exactly SEQ_LEN cycles. At completion, `src_flags` becomes 4'b0001 for software or 4'b0010 for watchdog. The watchdog strobe wins if both strobes arrive together.
- R3: When `flash_strap` is high at the start of a sequence, `int_rst` lasts SEQ_LEN+FLASH_EXT cycles.
- R4: If `bden` is set when a software or watchdog reset starts, `pin_pull` is high for the first SEQ_LEN cycles of the sequence, and only while `int_rst` is high.
- R5: Starting any reset sequence clears `bden`, and `bden` stays low while `int_rst` is high. `bden_set` sets it again only while the sequencer is idle.
- R6: If `pdn_level` is low when the software or watchdog reset starts, the pin is never pulled, and the sequence still runs and records its source.
- R7: If `pdn_level` falls while the pin is being pulled, `pin_pull` drops in the same cycle and stays low. `int_rst` still lasts the full length.
- R8: After a bidirectional sequence ends, the filtered pin level is sampled GAP_CYC cycles later. If it is low, a hardware reset follows, and its completion replaces the recorded source with short hardware (4'b0100).
- R9: If the filtered level stays low for at least LONG_THR cycles counted from the end of the sequence, the degraded reset is recorded as long hardware (4'b1000).
- R10: With `flash_strap` high, a bidirectional reset does not degrade, and the software or watchdog source remains recorded.
- R11: Software and watchdog strobes that arrive while a sequence is running are ignored.
- R12: A low level on the reset pin while idle starts a hardware reset. It is recorded as 4'b0100 if the filtered low lasted fewer than LONG_THR cycles, otherwise as 4'b1000.
- R13: `src_flags` is at most one-hot and changes only in the cycle a sequence completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| pin_level | input | 1 | Raw level seen on the open-drain reset pin |
| pdn_level | input | 1 | Power-down pin level; low inhibits pin drive |
| sw_req | input | 1 | Software reset strobe |
| wdt_req | input | 1 | Watchdog timeout strobe |
| bden_set | input | 1 | Write that arms bidirectional mode |
| flash_strap | input | 1 | Internal-flash strap; extends the internal reset |
| int_rst | output | 1 | Internal reset, active high |
| pin_pull | output | 1 | Pull-down enable for the reset pin |
| bden | output | 1 | Bidirectional mode armed |
| src_flags | output | 4 | One-hot source: bit0 software, bit1 watchdog, bit2 short hardware, bit3 long hardware |

## Verification
The bench builds the block with SEQ_LEN=32, FLASH_EXT=20, FILT_DLY=12, GAP_CYC=8 and LONG_THR=20. With a filter delay longer than the sampling gap, every bidirectional reset without the strap degrades into a short hardware reset, with an exactly predictable total length of 69 reset cycles. A 20-cycle flash extension pushes the sample past the filter delay. The 20-cycle long threshold lets a short external hold and a long one both fall in a few dozen cycles.

// File: rtl/bidir_rst_seq.sv
`timescale 1ns/1ps
module bidir_rst_seq #(
  parameter int SEQ_LEN   = 1024,
  parameter int FLASH_EXT = 4096,
  parameter int FILT_DLY  = 16,
  parameter int GAP_CYC   = 8,
  parameter int LONG_THR  = 64
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       pin_level,
  input  logic       pdn_level,
  input  logic       sw_req,
  input  logic       wdt_req,
  input  logic       bden_set,
  input  logic       flash_strap,
  output logic       int_rst,
  output logic       pin_pull,
  output logic       bden,
  output logic [3:0] src_flags
);
  localparam int TOT = SEQ_LEN + FLASH_EXT;
  localparam int CW  = $clog2(TOT + 1);
  localparam int GW  = $clog2(GAP_CYC + 1);
  localparam int LW  = $clog2(LONG_THR + 1);

  typedef enum logic [1:0] {S_IDLE, S_SEQ, S_GAP, S_HWLOW} st_t;

  st_t                st;
  logic [FILT_DLY-1:0] fpipe;
  logic [CW-1:0]      cnt;
  logic [GW-1:0]      gcnt;
  logic [LW-1:0]      lowcnt;
  logic [3:0]         src;
  logic               drive, bdseq, strap_q;

  wire filt     = fpipe[FILT_DLY-1];
  wire seq_last = (st == S_SEQ) &&
                  (cnt == (strap_q ? CW'(TOT - 1) : CW'(SEQ_LEN - 1)));
  wire low_sat  = (lowcnt == LW'(LONG_THR));

  assign int_rst  = (st == S_SEQ) || (st == S_HWLOW);
  assign pin_pull = (st == S_SEQ) && drive && pdn_level && (cnt < CW'(SEQ_LEN));

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) fpipe <= '1;
    else        fpipe <= {fpipe[FILT_DLY-2:0], pin_level};

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      gcnt      <= '0;
      lowcnt    <= '0;
      src       <= '0;
      src_flags <= '0;
      drive     <= 1'b0;
      bdseq     <= 1'b0;
      strap_q   <= 1'b0;
      bden      <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: begin
          if (!filt) begin
            st     <= S_HWLOW;
            lowcnt <= LW'(1);
            bden   <= 1'b0;
          end else if (sw_req || wdt_req) begin
            st      <= S_SEQ;
            cnt     <= '0;
            src     <= wdt_req ? 4'b0010 : 4'b0001;
            drive   <= bden && pdn_level;
            bdseq   <= bden;
            strap_q <= flash_strap;
            bden    <= 1'b0;
          end else if (bden_set) begin
            bden <= 1'b1;
          end
        end
        S_SEQ: begin
          if (!pdn_level) drive <= 1'b0;
          if (seq_last) begin
            src_flags <= src;
            st        <= bdseq ? S_GAP : S_IDLE;
            gcnt      <= '0;
            lowcnt    <= '0;
            drive     <= 1'b0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        S_GAP: begin
          if (!filt && !low_sat) lowcnt <= lowcnt + LW'(1);
          if (gcnt == GW'(GAP_CYC - 1)) st <= filt ? S_IDLE : S_HWLOW;
          else                          gcnt <= gcnt + GW'(1);
        end
        S_HWLOW: begin
          if (!filt) begin
            if (!low_sat) lowcnt <= lowcnt + LW'(1);
          end else begin
            st      <= S_SEQ;
            cnt     <= '0;
            src     <= low_sat ? 4'b1000 : 4'b0100;
            drive   <= 1'b0;
            bdseq   <= 1'b0;
            strap_q <= flash_strap;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R4
  pull_in_rst_chk: assert property (@(posedge clk) disable iff (!por_n)
    pin_pull |-> int_rst);
  // R4
  pull_start_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(pin_pull) |-> $rose(int_rst));
  // R5
  bden_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
    int_rst |-> !bden);
  // R13
  flags_onehot_chk: assert property (@(posedge clk) disable iff (!por_n)
    $onehot0(src_flags));
  // R13
  flags_at_end_chk: assert property (@(posedge clk) disable iff (!por_n)
    !$stable(src_flags) |-> $fell(int_rst));
  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    (st == S_SEQ && !seq_last) |=> (st == S_SEQ && src == $past(src)));
endmodule

// File: tb/tb_bidir_rst_seq.sv
`timescale 1ns/1ps
module tb_bidir_rst_seq;
  localparam int SEQ = 32, EXT = 20, FD = 12, GAP = 8, LTH = 20;

  logic clk = 0, por_n = 0, ext_low = 0, pdn_level = 1;
  logic sw_req = 0, wdt_req = 0, bden_set = 0, flash_strap = 0;
  logic int_rst, pin_pull, bden;
  logic [3:0] src_flags;
  wire pin_level = !(pin_pull || ext_low);
  int checks = 0, failures = 0;
  int nrst, npull;

  always #4 clk = ~clk;

  bidir_rst_seq #(.SEQ_LEN(SEQ), .FLASH_EXT(EXT), .FILT_DLY(FD),
                  .GAP_CYC(GAP), .LONG_THR(LTH)) dut (
    .clk(clk), .por_n(por_n), .pin_level(pin_level), .pdn_level(pdn_level),
    .sw_req(sw_req), .wdt_req(wdt_req), .bden_set(bden_set),
    .flash_strap(flash_strap), .int_rst(int_rst), .pin_pull(pin_pull),
    .bden(bden), .src_flags(src_flags));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(input int cyc);
    for (int i = 0; i < cyc; i++) begin
      nrst  += int_rst;
      npull += pin_pull;
      @(negedge clk);
    end
  endtask

  task automatic strobe(input bit wdt);
    nrst = 0; npull = 0;
    @(negedge clk);
    if (wdt) wdt_req = 1; else sw_req = 1;
    @(negedge clk);
    sw_req = 0; wdt_req = 0;
  endtask

  task automatic arm();
    @(negedge clk); bden_set = 1;
    @(negedge clk); bden_set = 0;
    chk(bden == 1, "R5 bden armed", bden, 1);
  endtask

  task automatic t_plain();
    strobe(0); measure(150);
    chk(nrst == SEQ, "R2 sw length", nrst, SEQ);
    chk(src_flags == 4'b0001, "R2 sw flag", src_flags, 1);
    chk(npull == 0, "R4 no pull when unarmed", npull, 0);
    strobe(1); measure(10);
    chk(src_flags == 4'b0001, "R13 flags held mid-sequence", src_flags, 1);
    measure(140);
    chk(nrst == SEQ, "R2 wdt length", nrst, SEQ);
    chk(src_flags == 4'b0010, "R2 wdt flag", src_flags, 2);
  endtask

  task automatic t_strap();
    flash_strap = 1;
    strobe(0); measure(150);
    chk(nrst == SEQ + EXT, "R3 strap length", nrst, SEQ + EXT);
    flash_strap = 0;
  endtask

  task automatic t_degrade();
    arm(); strobe(0); measure(SEQ + 3);
    chk(npull == SEQ, "R4 pull length", npull, SEQ);
    chk(bden == 0, "R5 bden cleared", bden, 0);
    chk(src_flags == 4'b0001, "R8 sw first recorded", src_flags, 1);
    measure(150);
    chk(src_flags == 4'b0100, "R8 degraded to short hw", src_flags, 4);
    chk(nrst == 69, "R8 total reset cycles", nrst, 69);
    chk(bden == 0, "R5 bden stays cleared", bden, 0);
  endtask

  task automatic t_long();
    arm(); strobe(1);
    for (int i = 0; i < 200; i++) begin
      if (i == 20) ext_low = 1;
      if (i == SEQ + 30) ext_low = 0;
      #1;
      nrst += int_rst;
      @(negedge clk);
    end
    chk(src_flags == 4'b1000, "R9 degraded to long hw", src_flags, 8);
  endtask

  task automatic t_strap_bidir();
    arm(); flash_strap = 1;
    strobe(0); measure(200);
    chk(npull == SEQ, "R10 pull length with strap", npull, SEQ);
    chk(nrst == SEQ + EXT, "R10 no extra reset", nrst, SEQ + EXT);
    chk(src_flags == 4'b0001, "R10 sw kept", src_flags, 1);
    flash_strap = 0;
  endtask

  task automatic t_pdn_low();
    arm(); pdn_level = 0;
    strobe(1); measure(150);
    chk(npull == 0, "R6 no pull with pdn low", npull, 0);
    chk(nrst == SEQ, "R6 length", nrst, SEQ);
    chk(src_flags == 4'b0010, "R6 wdt flag", src_flags, 2);
    pdn_level = 1;
  endtask

  task automatic t_pdn_mid();
    bit drop_ok = 1;
    arm(); strobe(0);
    for (int i = 0; i < 150; i++) begin
      if (i == 10) pdn_level = 0;
      #1;
      if (i == 10 && pin_pull) drop_ok = 0;
      nrst += int_rst; npull += pin_pull;
      @(negedge clk);
    end
    chk(drop_ok, "R7 immediate release", !drop_ok, 0);
    chk(npull == 10, "R7 pull cycles", npull, 10);
    chk(nrst == SEQ, "R7 full internal length", nrst, SEQ);
    chk(src_flags == 4'b0001, "R7 sw flag", src_flags, 1);
    pdn_level = 1;
  endtask

  task automatic t_busy();
    strobe(1); measure(5);
    wdt_req = 0; sw_req = 1; @(negedge clk); sw_req = 0;
    nrst += 1;
    measure(150);
    chk(nrst == SEQ, "R11 no restart", nrst, SEQ);
    chk(src_flags == 4'b0010, "R11 wdt kept", src_flags, 2);
  endtask

  task automatic t_hw(input int w, input logic [3:0] exp);
    @(negedge clk); ext_low = 1;
    repeat (w) @(negedge clk);
    ext_low = 0;
    repeat (150) @(negedge clk);
    chk(src_flags == exp, "R12 hw pin classification", src_flags, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(int_rst == 0 && pin_pull == 0, "R1 outputs idle in reset", int_rst, 0);
    por_n = 1;
    @(negedge clk);
    chk(bden == 0, "R1 bden low", bden, 0);
    chk(src_flags == 0, "R1 flags clear", src_flags, 0);
    chk(int_rst == 0, "R1 no reset running", int_rst, 0);
    t_plain();
    t_strap();
    t_degrade();
    t_long();
    t_strap_bidir();
    t_pdn_low();
    t_pdn_mid();
    t_busy();
    t_hw(5, 4'b0100);
    t_hw(30, 4'b1000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++; failures++;
    $display("FAIL watchdog timeout actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule